// File: doc/BRIEF.md
# Programmable Down-Counting Timer with Square-Wave Output

The block holds a 16-bit down-counter with a preload value. Software writes the preload as an upper byte and a lower byte. A mode field chooses how the counter runs and what clocks it. In timer mode the counter runs without stopping and reloads itself, so its wave output is a square wave with a half period set by the preload. In counter mode a start strobe loads the preload once, and the counter then counts down as a one-shot. A ready flag is raised for the interrupt logic, and a stop strobe clears it. The wave can be routed to a general-purpose output pin.

The counter decrements only on a count tick. The tick comes from one of three sources: a rising edge on an external pin, a pulse of the oscillator enable, or that enable divided by a prescaler. The start and stop strobes are single-cycle pulses that the bus decoder produces from reads of two addresses.

Top module: `ctr_timer16`

## Requirements
- R1: A pulse on `wr_hi` stores `wr_data` as preload bits 15:8, and a pulse on `wr_lo` stores it as bits 7:0. A start strobe copies the whole preload into `count` on the next clock edge. No tick is taken in that cycle.
- R2: In counter mode, once started, each tick lowers `count` by one. The tick that takes `count` from 1 to 0 sets `ready` and drives `wave` high. Counting continues through FFFFh. A start drives `wave` low.
- R3: A preload of zero gives 65536 ticks from a start to the point where `ready` is set.
- R4: In timer mode (`mode_sel[2]`=1), a tick seen while `count` is 1 reloads the preload and toggles `wave`, so each half period lasts preload ticks. A start reloads and drives `wave` low. A stop does not halt the count.
- R5: In timer mode, `ready` is set each time `wave` goes from low to high, which is once per full square-wave cycle.
- R6: A stop strobe clears `ready` on the next edge unless a set happens in the same cycle, in which case the set wins. In counter mode a stop also halts the count, and ticks are ignored until the next start. Stop wins over start.
- R7: `mode_sel[1:0]` selects the tick. 00 gives one tick per rising edge of `ext_pin`, however long the pin stays high, and `osc_tick` is then ignored. 01 and 11 give a tick on every `osc_tick` pulse.
- R8: `mode_sel[1:0]`=10 gives one tick per 16 `osc_tick` pulses. A start clears the prescaler, so the first tick comes on the 16th pulse after the start.
- R9: `pin_out` shows `wave` when `pin_sel`=1 and shows `gpo_val` when `pin_sel`=0.
- R10: After reset, `count`, `wave`, `ready` and the preload are all zero, and counter mode is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_hi | input | 1 | Write strobe for the preload upper byte |
| wr_lo | input | 1 | Write strobe for the preload lower byte |
| wr_data | input | 8 | Byte to store in the preload |
| mode_sel | input | 3 | Bit 2: timer mode; bits 1:0: tick source |
| ext_pin | input | 1 | External count input, synchronous to `clk` |
| osc_tick | input | 1 | Oscillator enable pulse |
| start_cmd | input | 1 | Start/restart strobe |
| stop_cmd | input | 1 | Stop strobe, also clears ready |
| pin_sel | input | 1 | Selects the wave as the pin output |
| gpo_val | input | 1 | Pin value used when the wave is not selected |
| count | output | 16 | Current counter value |
| wave | output | 1 | Square-wave / terminal-count output |
| ready | output | 1 | Ready flag for the interrupt logic |
| pin_out | output | 1 | General-purpose output pin |

## Verification
The assertions assume that `ext_pin` is already synchronous to `clk`, that `start_cmd` and `stop_cmd` are single-cycle strobes, and that `mode_sel` is not changed while a count is in flight. The stimulus therefore changes the mode and the preload only while the tick source is idle, and it drives every input half a cycle away from the sampling edge. Each tick source is held at a known phase before a start, so that every expected reload, toggle and flag edge falls on a cycle that can be computed.

// File: rtl/ctmr_pkg.sv
`timescale 1ns/1ps
package ctmr_pkg;
    typedef enum logic [1:0] {
        SRC_PIN  = 2'b00,
        SRC_OSC  = 2'b01,
        SRC_DIV  = 2'b10,
        SRC_OSC2 = 2'b11
    } src_e;
endpackage

// File: rtl/ctmr_preload.sv
`timescale 1ns/1ps
module ctmr_preload #(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_hi,
    input  logic                 wr_lo,
    input  logic [CNT_W/2-1:0]   wr_data,
    output logic [CNT_W-1:0]     preload
);
    localparam int BYTE_W = CNT_W / 2;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } pl_t;

    pl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_hi) r_d.hi = wr_data;
        if (wr_lo) r_d.lo = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign preload = {r_q.hi, r_q.lo};

    // R1: a lower-byte write leaves the upper byte alone
    assert_hi_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (preload[CNT_W-1:BYTE_W] == $past(preload[CNT_W-1:BYTE_W])));
endmodule

// File: rtl/ctmr_tick_sel.sv
`timescale 1ns/1ps
module ctmr_tick_sel
    import ctmr_pkg::*;
#(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  src_e src,
    input  logic ext_pin,
    input  logic osc_tick,
    input  logic clr_pre,
    output logic tick
);
    localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic             ext_prev;
        logic [PRE_W-1:0] pre;
    } ts_t;

    ts_t s_d, s_q;
    logic div_tick;
    logic pin_tick;

    assign pin_tick = ext_pin & ~s_q.ext_prev;

    generate
        if (DIV > 1) begin : g_pre
            localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);
            assign div_tick = osc_tick & (s_q.pre == LAST) & ~clr_pre;
            always_comb begin
                s_d          = s_q;
                s_d.ext_prev = ext_pin;
                if (clr_pre)       s_d.pre = '0;
                else if (osc_tick) s_d.pre = (s_q.pre == LAST) ? '0 : s_q.pre + 1'b1;
            end
        end else begin : g_nopre
            assign div_tick = osc_tick & ~clr_pre;
            always_comb begin
                s_d          = s_q;
                s_d.ext_prev = ext_pin;
                s_d.pre      = '0;
            end
        end
    endgenerate

    always_comb begin
        case (src)
            SRC_PIN: tick = pin_tick;
            SRC_DIV: tick = div_tick;
            default: tick = osc_tick;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: an external pin held high yields a single tick
    assert_pin_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_PIN && tick) |=> !(src == SRC_PIN && tick));
    // R8: divided ticks only come with an oscillator pulse
    assert_div_osc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_DIV && tick) |-> osc_tick);
endmodule

// File: rtl/ctmr_core.sv
`timescale 1ns/1ps
module ctmr_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             timer_mode,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    input  logic [CNT_W-1:0] preload,
    output logic [CNT_W-1:0] count,
    output logic             wave,
    output logic             ready
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wave;
        logic             ready;
        logic             run;
    } st_t;

    st_t  s_d, s_q;
    logic set_rdy;

    always_comb begin
        s_d     = s_q;
        set_rdy = 1'b0;
        if (timer_mode) begin
            if (start) begin
                s_d.cnt  = preload;
                s_d.wave = 1'b0;
            end else if (tick) begin
                if (s_q.cnt == ONE) begin
                    s_d.cnt  = preload;
                    s_d.wave = ~s_q.wave;
                    set_rdy  = ~s_q.wave;
                end else begin
                    s_d.cnt = s_q.cnt - ONE;
                end
            end
        end else begin
            if (stop) begin
                s_d.run = 1'b0;
            end else if (start) begin
                s_d.cnt  = preload;
                s_d.wave = 1'b0;
                s_d.run  = 1'b1;
            end else if (tick && s_q.run) begin
                s_d.cnt = s_q.cnt - ONE;
                if (s_q.cnt == ONE) begin
                    s_d.wave = 1'b1;
                    set_rdy  = 1'b1;
                end
            end
        end
        if (set_rdy)   s_d.ready = 1'b1;
        else if (stop) s_d.ready = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;
    assign wave  = s_q.wave;
    assign ready = s_q.ready;

    // R1: an accepted start loads the preload
    assert_start_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (timer_mode || !stop)) |=> (s_q.cnt == $past(preload)));
    // R4: the timer wave moves only on a tick or a start
    assert_wave_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_mode && !tick && !start) |=> $stable(s_q.wave));
    // R5: ready only rises on a tick
    assert_rdy_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ready) |-> $past(tick));
    // R6: a stop without a competing set clears ready
    assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !tick) |=> !s_q.ready);
    // R6: a halted one-shot holds its count
    assert_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!timer_mode && !s_q.run && !start) |=> $stable(s_q.cnt));
endmodule

// File: rtl/ctr_timer16.sv
`timescale 1ns/1ps
module ctr_timer16
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_hi,
    input  logic                 wr_lo,
    input  logic [CNT_W/2-1:0]   wr_data,
    input  logic [2:0]           mode_sel,
    input  logic                 ext_pin,
    input  logic                 osc_tick,
    input  logic                 start_cmd,
    input  logic                 stop_cmd,
    input  logic                 pin_sel,
    input  logic                 gpo_val,
    output logic [CNT_W-1:0]     count,
    output logic                 wave,
    output logic                 ready,
    output logic                 pin_out
);
    logic [CNT_W-1:0] preload;
    logic             tick;
    src_e             src;

    assign src = src_e'(mode_sel[1:0]);

    ctmr_preload #(.CNT_W(CNT_W)) u_preload (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wr_data (wr_data),
        .preload (preload)
    );

    ctmr_tick_sel #(.DIV(DIV)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .ext_pin  (ext_pin),
        .osc_tick (osc_tick),
        .clr_pre  (start_cmd),
        .tick     (tick)
    );

    ctmr_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .timer_mode (mode_sel[2]),
        .tick       (tick),
        .start      (start_cmd),
        .stop       (stop_cmd),
        .preload    (preload),
        .count      (count),
        .wave       (wave),
        .ready      (ready)
    );

    assign pin_out = pin_sel ? wave : gpo_val;
endmodule

// File: tb/ctr_timer16_test.sv
`timescale 1ns/1ps
module ctr_timer16_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_hi = 0, wr_lo = 0;
    logic [7:0]  wr_data = 0;
    logic [2:0]  mode_sel = 0;
    logic        ext_pin = 0, osc_tick = 0, start_cmd = 0, stop_cmd = 0;
    logic        pin_sel = 0, gpo_val = 0;
    logic [15:0] count;
    logic        wave, ready, pin_out;

    always #2.5 clk = ~clk;

    ctr_timer16 uut (
        .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
        .mode_sel(mode_sel), .ext_pin(ext_pin), .osc_tick(osc_tick),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd), .pin_sel(pin_sel),
        .gpo_val(gpo_val), .count(count), .wave(wave), .ready(ready), .pin_out(pin_out)
    );

    typedef struct {
        int          cyc;
        int          fld;
        logic [15:0] val;
        string       tag;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    localparam int F_CNT = 0, F_WAVE = 1, F_RDY = 2, F_PIN = 3;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] field(input int f);
        case (f)
            F_CNT:   return count;
            F_WAVE:  return {15'd0, wave};
            F_RDY:   return {15'd0, ready};
            default: return {15'd0, pin_out};
        endcase
    endfunction

    task automatic exp_at(input int dc, input int f, input logic [15:0] v, input string tag);
        item_t it;
        int pos;
        it.cyc = cyc + dc; it.fld = f; it.val = v; it.tag = tag;
        pos = sb.size();
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc > it.cyc) pos = i;
        end
        sb.insert(pos, it);
    endtask

    // monitor: pops expected items as their cycle arrives
    item_t       mon_it;
    logic [15:0] mon_got;
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            mon_it  = sb.pop_front();
            mon_got = field(mon_it.fld);
            checks++;
            if (mon_it.cyc != cyc || mon_got !== mon_it.val) begin
                errors++;
                $display("FAIL %s field %0d cycle %0d: actual %h expected %h",
                         mon_it.tag, mon_it.fld, mon_it.cyc, mon_got, mon_it.val);
            end
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic load(input logic [15:0] v);
        wr_hi = 1; wr_data = v[15:8]; step();
        wr_hi = 0; wr_lo = 1; wr_data = v[7:0]; step();
        wr_lo = 0;
    endtask

    task automatic halt();
        osc_tick = 0; stop_cmd = 1; step();
        stop_cmd = 0; step();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1;
        // R10: reset state
        exp_at(1, F_CNT, 16'h0000, "R10");
        exp_at(1, F_WAVE, 0, "R10");
        exp_at(1, F_RDY, 0, "R10");
        exp_at(1, F_PIN, 0, "R10");
        step(2);

        // R1: byte writes and load on start
        mode_sel = 3'b001;
        load(16'h1234);
        start_cmd = 1; osc_tick = 1;
        exp_at(1, F_CNT, 16'h1234, "R1");
        exp_at(2, F_CNT, 16'h1233, "R2");
        step(); start_cmd = 0; step(2);
        halt();

        // R2/R6: one-shot of five ticks, then stop
        load(16'h0005);
        start_cmd = 1; osc_tick = 1;
        exp_at(1, F_CNT, 16'd5, "R2");
        exp_at(1, F_WAVE, 0, "R2");
        exp_at(5, F_RDY, 0, "R2");
        exp_at(5, F_WAVE, 0, "R2");
        exp_at(6, F_RDY, 1, "R2");
        exp_at(6, F_WAVE, 1, "R2");
        exp_at(6, F_CNT, 16'h0000, "R2");
        exp_at(7, F_CNT, 16'hFFFF, "R2");
        step(); start_cmd = 0; step(7);
        stop_cmd = 1;
        exp_at(1, F_RDY, 0, "R6");
        exp_at(1, F_CNT, 16'hFFFE, "R6");
        exp_at(4, F_CNT, 16'hFFFE, "R6");
        step(); stop_cmd = 0; step(5);
        osc_tick = 0;

        // R4/R5/R9: timer with half period of 3
        mode_sel = 3'b101; pin_sel = 1;
        load(16'h0003);
        start_cmd = 1; osc_tick = 1;
        exp_at(1, F_CNT, 16'd3, "R4");
        exp_at(1, F_WAVE, 0, "R4");
        exp_at(1, F_PIN, 0, "R9");
        exp_at(3, F_WAVE, 0, "R4");
        exp_at(3, F_RDY, 0, "R5");
        exp_at(4, F_CNT, 16'd3, "R4");
        exp_at(4, F_WAVE, 1, "R4");
        exp_at(4, F_RDY, 1, "R5");
        exp_at(4, F_PIN, 1, "R9");
        exp_at(5, F_CNT, 16'd2, "R4");
        step(); start_cmd = 0; step(4);
        stop_cmd = 1;
        exp_at(1, F_RDY, 0, "R6");
        exp_at(1, F_WAVE, 1, "R4");
        exp_at(2, F_CNT, 16'd3, "R4");
        exp_at(2, F_WAVE, 0, "R4");
        exp_at(2, F_PIN, 0, "R9");
        exp_at(4, F_RDY, 0, "R5");
        exp_at(5, F_RDY, 1, "R5");
        exp_at(5, F_WAVE, 1, "R4");
        step(); stop_cmd = 0; step(6);
        halt();
        pin_sel = 0; gpo_val = 1;
        exp_at(1, F_PIN, 1, "R9");
        step(2); gpo_val = 0;

        // R7: external pin edges, oscillator ignored
        mode_sel = 3'b000;
        load(16'h0002);
        osc_tick = 1; start_cmd = 1;
        exp_at(1, F_CNT, 16'd2, "R7");
        exp_at(3, F_CNT, 16'd1, "R7");
        exp_at(5, F_CNT, 16'd1, "R7");
        exp_at(6, F_RDY, 0, "R7");
        exp_at(7, F_CNT, 16'd0, "R7");
        exp_at(7, F_RDY, 1, "R7");
        step(); start_cmd = 0; step();
        ext_pin = 1; step(3);
        ext_pin = 0; step();
        ext_pin = 1; step();
        ext_pin = 0; step(2);
        halt();

        // R8: divide-by-16 source
        mode_sel = 3'b010;
        load(16'h0002);
        start_cmd = 1; osc_tick = 1;
        exp_at(1, F_CNT, 16'd2, "R8");
        exp_at(16, F_CNT, 16'd2, "R8");
        exp_at(17, F_CNT, 16'd1, "R8");
        exp_at(32, F_CNT, 16'd1, "R8");
        exp_at(32, F_RDY, 0, "R8");
        exp_at(33, F_CNT, 16'd0, "R8");
        exp_at(33, F_RDY, 1, "R8");
        step(); start_cmd = 0; step(35);
        halt();

        // R3: zero preload, source code 11 acts as oscillator (R7)
        mode_sel = 3'b011;
        load(16'h0000);
        start_cmd = 1; osc_tick = 1;
        exp_at(1, F_CNT, 16'h0000, "R3");
        exp_at(2, F_CNT, 16'hFFFF, "R7");
        exp_at(2, F_RDY, 0, "R3");
        exp_at(65536, F_RDY, 0, "R3");
        exp_at(65537, F_RDY, 1, "R3");
        exp_at(65537, F_CNT, 16'h0000, "R3");
        step(); start_cmd = 0; step(65540);
        halt();

        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        if (!done) begin
            done = 1;
            summary();
            $finish;
        end
    end
endmodule